// File: doc/BRIEF.md
# Programmable Sync Word Detector

This block watches a serial bit stream coming out of a demodulator and flags the point where a synchronization pattern has just been received. That point marks the start of payload data. Bits are accepted one per clock on cycles where a valid strobe is high. The newest bit enters at the least significant end of a history register, so the first bit received ends up as the most significant bit of the pattern.

The pattern has a fixed upper byte of 0x2D and a lower byte set through a configuration input. A runtime select chooses between two match lengths. In byte mode only the lower byte is compared. In word mode the 16-bit value {0x2D, lower byte} is compared.

When the pattern is found, the block raises a one-cycle match pulse and an alignment level. The alignment level tells a downstream payload buffer that the next valid bit is the first payload bit. Once a match has occurred, detection is disarmed until the enable input is dropped and raised again. This keeps payload bytes from retriggering the detector.

Top module: `sync_word_detect`

## Requirements
- R1: After reset, `match_o` and `aligned_o` are both 0.
- R2: In byte mode (`word_mode_i` = 0), a match occurs when the last 8 accepted bits equal `low_byte_i`. The first bit received is bit 7 of the pattern.
- R3: In word mode (`word_mode_i` = 1), a match occurs only when the last 16 accepted bits equal {8'h2D, `low_byte_i`}. The first bit received is bit 15 of the pattern. The lower byte alone does not match, and neither does a wrong upper byte.
- R4: `match_o` is high for exactly one clock cycle. It is high in the cycle that follows the clock edge at which the bit completing the pattern is accepted.
- R5: A bit is accepted only at a clock edge where both `en_i` and `bit_vld_i` are high. Cycles with `bit_vld_i` low leave the history unchanged, so idle gaps between bits do not break a pattern.
- R6: After a match, no further match occurs while `en_i` stays high, even if the pattern repeats. After `en_i` is taken low and then high again, detection is armed once more.
- R7: A match counts only bits accepted since `en_i` last went high, and needs at least 8 such bits (byte mode) or 16 (word mode). Bits accepted before `en_i` went low do not count, and the cleared history never counts as zeros.
- R8: `aligned_o` goes high together with `match_o`. It stays high until the first clock edge at which `en_i` is low.
- R9: While `en_i` is low, `match_o` stays 0 and `bit_in_i` is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Detection enable; a low level clears the history and re-arms detection |
| bit_vld_i | input | 1 | Strobe that marks `bit_in_i` as a valid received bit |
| bit_in_i | input | 1 | Received serial bit |
| low_byte_i | input | 8 | Programmable lower byte of the pattern |
| word_mode_i | input | 1 | 0: 8-bit pattern, 1: 16-bit pattern |
| match_o | output | 1 | One-cycle pulse when the pattern is found |
| aligned_o | output | 1 | High from a match until enable is dropped |

## Verification
The hardest case to reach is one where bits already in the history, or the zeros left in it after a clear, would line up with the pattern. This happens when bits received before enable was dropped complete the pattern, or when the lower byte is 0x00 and only a few bits have arrived since enable went high. Directed sequences split a pattern across an enable toggle and program the lower byte to 0x00. Random streams with embedded patterns and idle gaps then check that a repeated pattern after a match stays silent.

// File: rtl/sync_pkg.sv
package sync_pkg;
    localparam int unsigned BYTE_W  = 8;
    localparam int unsigned HIST_W  = 2 * BYTE_W;
    localparam int unsigned CNT_W   = $clog2(HIST_W + 1);
    localparam logic [BYTE_W-1:0] FIXED_HI = 8'h2D;

    typedef struct packed {
        logic [HIST_W-1:0] hist;
        logic [CNT_W-1:0]  cnt;
        logic              armed;
        logic              match;
        logic              aligned;
    } det_state_t;
endpackage

// File: rtl/sync_hist_step.sv
module sync_hist_step
    import sync_pkg::*;
(
    input  logic [HIST_W-1:0] hist_i,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic              bit_i,
    output logic [HIST_W-1:0] hist_o,
    output logic [CNT_W-1:0]  cnt_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(HIST_W);

    always_comb begin
        hist_o = {hist_i[HIST_W-2:0], bit_i};
        cnt_o  = (cnt_i == CNT_MAX) ? cnt_i : cnt_i + 1'b1;
    end
endmodule

// File: rtl/sync_cmp.sv
module sync_cmp
    import sync_pkg::*;
(
    input  logic [HIST_W-1:0] hist_i,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic [BYTE_W-1:0] low_byte_i,
    input  logic              word_mode_i,
    output logic              hit_o
);
    localparam logic [CNT_W-1:0] NEED_BYTE = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] NEED_WORD = CNT_W'(HIST_W);

    logic [HIST_W-1:0] pattern;
    logic [HIST_W-1:0] bit_eq;
    assign pattern = {FIXED_HI, low_byte_i};

    for (genvar i = 0; i < HIST_W; i++) begin : g_eq
        assign bit_eq[i] = ~(hist_i[i] ^ pattern[i]);
    end

    logic lo_ok, hi_ok;
    always_comb begin
        lo_ok = &bit_eq[BYTE_W-1:0];
        hi_ok = &bit_eq[HIST_W-1:BYTE_W];
        if (word_mode_i)
            hit_o = lo_ok && hi_ok && (cnt_i >= NEED_WORD);
        else
            hit_o = lo_ok && (cnt_i >= NEED_BYTE);
    end
endmodule

// File: rtl/sync_word_detect.sv
module sync_word_detect
    import sync_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              en_i,
    input  logic              bit_vld_i,
    input  logic              bit_in_i,
    input  logic [BYTE_W-1:0] low_byte_i,
    input  logic              word_mode_i,
    output logic              match_o,
    output logic              aligned_o
);
    det_state_t st_d, st_q;

    logic [HIST_W-1:0] hist_nx;
    logic [CNT_W-1:0]  cnt_nx;
    logic              hit;

    sync_hist_step u_step (
        .hist_i (st_q.hist),
        .cnt_i  (st_q.cnt),
        .bit_i  (bit_in_i),
        .hist_o (hist_nx),
        .cnt_o  (cnt_nx)
    );

    sync_cmp u_cmp (
        .hist_i      (hist_nx),
        .cnt_i       (cnt_nx),
        .low_byte_i  (low_byte_i),
        .word_mode_i (word_mode_i),
        .hit_o       (hit)
    );

    always_comb begin
        st_d       = st_q;
        st_d.match = 1'b0;
        if (!en_i) begin
            st_d.hist    = '0;
            st_d.cnt     = '0;
            st_d.armed   = 1'b1;
            st_d.aligned = 1'b0;
        end else if (bit_vld_i) begin
            st_d.hist = hist_nx;
            st_d.cnt  = cnt_nx;
            if (st_q.armed && hit) begin
                st_d.match   = 1'b1;
                st_d.aligned = 1'b1;
                st_d.armed   = 1'b0;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q       <= '0;
            st_q.armed <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign match_o   = st_q.match;
    assign aligned_o = st_q.aligned;

    AST_PULSE_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        match_o |=> !match_o); // R4
    AST_MATCH_NEEDS_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        match_o |-> $past(en_i && bit_vld_i)); // R5
    AST_BYTE_CONTENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (match_o && !$past(word_mode_i)) |-> (st_q.hist[BYTE_W-1:0] == $past(low_byte_i))); // R2
    AST_WORD_CONTENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (match_o && $past(word_mode_i)) |-> (st_q.hist == {FIXED_HI, $past(low_byte_i)})); // R3
    AST_NO_REARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(aligned_o) |-> !match_o); // R6
    AST_EN_LOW_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$past(en_i) |-> (!match_o && !aligned_o)); // R9
    AST_ALIGN_WITH_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(aligned_o) |-> match_o); // R8
endmodule

// File: tb/tb_sync_word_detect.sv
module tb_sync_word_detect;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0, vld = 1'b0, bin = 1'b0, wmode = 1'b0;
    logic [7:0] low = 8'h00;
    logic       match, aligned;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    logic [15:0] m_hist;
    int          m_cnt;
    bit          m_armed, e_match, e_aligned;

    always #5 clk = ~clk;

    sync_word_detect dut (
        .clk_i(clk), .rst_ni(rst_n), .en_i(en), .bit_vld_i(vld),
        .bit_in_i(bin), .low_byte_i(low), .word_mode_i(wmode),
        .match_o(match), .aligned_o(aligned)
    );

    function automatic bit pat_hit(logic [15:0] h, int c, logic [7:0] lb, bit wm);
        if (wm) return (c >= 16) && (h == {8'h2D, lb});
        return (c >= 8) && (h[7:0] == lb);
    endfunction

    task automatic check(string tag);
        n_chk++;
        if (match !== e_match || aligned !== e_aligned) begin
            n_fail++;
            $display("FAIL %s: match=%b aligned=%b expected match=%b aligned=%b",
                     tag, match, aligned, e_match, e_aligned);
        end
    endtask

    task automatic model_edge();
        e_match = 1'b0;
        if (!en) begin
            m_hist = '0; m_cnt = 0; m_armed = 1'b1; e_aligned = 1'b0;
        end else if (vld) begin
            m_hist = {m_hist[14:0], bin};
            if (m_cnt < 16) m_cnt++;
            if (m_armed && pat_hit(m_hist, m_cnt, low, wmode)) begin
                e_match = 1'b1; e_aligned = 1'b1; m_armed = 1'b0;
            end
        end
    endtask

    task automatic step(bit e, bit v, bit b, string tag);
        en = e; vld = v; bin = b;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check(tag);
    endtask

    task automatic send_byte(logic [7:0] x, string tag);
        for (int i = 7; i >= 0; i--) step(1'b1, 1'b1, x[i], tag);
    endtask

    task automatic toggle_en(string tag);
        step(1'b0, 1'b0, 1'b0, tag);
        step(1'b1, 1'b0, 1'b0, tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] sav;
        void'($urandom(32'd1234));
        m_hist = '0; m_cnt = 0; m_armed = 1'b1; e_match = 1'b0; e_aligned = 1'b0;
        repeat (3) @(negedge clk);
        check("R1");
        rst_n = 1'b1;
        @(negedge clk);
        check("R1");

        // R2: byte mode match on 0xA5
        low = 8'hA5; wmode = 1'b0;
        toggle_en("R7");
        send_byte(8'hA5, "R2");
        if (!e_match) begin n_chk++; n_fail++; $display("FAIL R2: match=0 expected 1"); end
        step(1'b1, 1'b0, 1'b0, "R4");
        // R6: repeat pattern, disarmed
        send_byte(8'hA5, "R6");
        step(1'b1, 1'b0, 1'b0, "R8");
        toggle_en("R8");
        send_byte(8'hA5, "R6");

        // R3: word mode, lower byte alone then wrong upper, then full
        wmode = 1'b1; low = 8'h3C;
        toggle_en("R3");
        send_byte(8'h3C, "R3");
        send_byte(8'h2C, "R3");
        send_byte(8'h3C, "R3");
        send_byte(8'h2D, "R3");
        send_byte(8'h3C, "R3");

        // R5: idle gaps inside a byte pattern
        wmode = 1'b0; low = 8'h96;
        toggle_en("R5");
        for (int i = 7; i >= 0; i--) begin
            step(1'b1, 1'b0, 1'b1, "R5");
            step(1'b1, 1'b1, low[i], "R5");
        end

        // R7: zero pattern needs 8 fresh bits; cleared history never counts
        low = 8'h00;
        toggle_en("R7");
        for (int i = 0; i < 8; i++) step(1'b1, 1'b1, 1'b0, "R7");
        // R7: pattern split across an enable drop
        low = 8'hF0;
        toggle_en("R7");
        for (int i = 0; i < 4; i++) step(1'b1, 1'b1, 1'b1, "R7");
        toggle_en("R7");
        for (int i = 0; i < 4; i++) step(1'b1, 1'b1, 1'b0, "R7");

        // R9: bits while enable is low ignored
        for (int i = 0; i < 10; i++) step(1'b0, 1'b1, i[0], "R9");

        // Random stream with embedded patterns
        for (int k = 0; k < 400; k++) begin
            wmode = 1'($urandom_range(0, 1));
            low   = 8'($urandom);
            toggle_en("R7");
            for (int j = 0; j < 40; j++) begin
                if ($urandom_range(0, 5) == 0) begin
                    if (wmode) send_byte(8'h2D, "R3");
                    sav = low;
                    send_byte(sav, wmode ? "R3" : "R2");
                end else begin
                    step(1'b1, 1'($urandom_range(0, 3) != 0), 1'($urandom), "R5");
                end
                if ($urandom_range(0, 60) == 0) step(1'b0, 1'b1, 1'($urandom), "R9");
            end
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule